// File: doc/BRIEF.md
# Nine-Bit Multidrop Receive Address Filter

This block sits behind a UART receiver on a shared multidrop line where each character carries eight data bits and a ninth marker bit in the slot normally used for parity. A ninth bit of 0 marks an ordinary data character. A ninth bit of 1 marks an address character that opens a new session. The filter takes each completed receive word as a data byte, a ninth bit and a one-cycle valid strobe. It compares address characters with the node's own address, which is held in a writable register. It keeps a session state that records whether this node is the current target.

Data characters reach the host side only while the node is selected, and everything else is dropped. Address characters are never forwarded as data. A match is reported by a one-cycle hit strobe instead. Any address character, whether it matches or not, can raise a sticky interrupt if the host has unmasked it. The interrupt stays set until the host pulses a clear. The block works on one word at a time, as each word arrives in the receive register, and has no queue.

A filter enable selects between filtered operation and a transparent mode. In transparent mode every word, of either kind, is passed through unchanged.

The session state machine has three states:
- `ST_BYPASS`: the filter is disabled.
- `ST_HUNT`: enabled, but this node is not addressed.
- `ST_SELECTED`: enabled, and this node is addressed.

Its transitions are:
- any state → `ST_BYPASS` when the enable is low.
- `ST_BYPASS` → `ST_HUNT` on the first enabled cycle without a matching address character.
- `ST_BYPASS`/`ST_HUNT` → `ST_SELECTED` on a matching address character.
- `ST_SELECTED` → `ST_HUNT` on a non-matching address character.
- `ST_SELECTED` → `ST_SELECTED` on a repeated matching address character, which fires the hit strobe again.

Data characters never change the state.

Top module: `mdrop_addr_filter`

## Requirements
- R1: Reset sets the outputs as follows: `addressed` = 0, `irq` = 0, `out_valid` = 0, `addr_hit` = 0. The node address register resets to 8'h00.
- R2: With the filter enabled, a valid word with ninth bit 1 whose byte equals the node address gives these results on the next clock edge: `addr_hit` = 1 for that one cycle, `addressed` = 1, and `out_valid` = 0 (the address word is not forwarded).
- R3: With the filter enabled, a valid word with ninth bit 1 whose byte differs from the node address leaves `addressed` = 0 after the next edge. It gives no `addr_hit` and no `out_valid`.
- R4: With the filter enabled and `addressed` = 1, a valid word with ninth bit 0 appears on the next edge as `out_valid` = 1, with `out_data` equal to its byte and `out_ninth` = 0.
- R5: With the filter enabled and `addressed` = 0, a valid word with ninth bit 0 is dropped: `out_valid` stays 0 and `addressed` stays 0.
- R6: When `irq_en` = 1, `irq` is 1 after the edge that takes any valid word with ninth bit 1. This holds whether or not the byte matches and whether or not the filter is enabled. When `irq_en` = 0, such a word does not set `irq`.
- R7: `irq` stays 1 until a cycle with `irq_clear` = 1, and is 0 after that edge. If the same cycle also sets it (per R6), the set wins and `irq` stays 1.
- R8: With the filter disabled, every valid word is forwarded on the next edge with its byte on `out_data` and its ninth bit on `out_ninth`. `addr_hit` stays 0 and `addressed` is 0.
- R9: `addr_wr` = 1 loads `addr_wdata` into the node address. A word arriving in the same cycle as the write is still compared with the old address. Words in later cycles use the new one.
- R10: `out_valid` and `addr_hit` are only ever 1 in the cycle right after a cycle with `rx_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_en | input | 1 | 1 = filtered operation, 0 = transparent |
| irq_en | input | 1 | Unmasks the address-character interrupt |
| irq_clear | input | 1 | Host acknowledge pulse that clears `irq` |
| addr_wr | input | 1 | Load strobe for the node address |
| addr_wdata | input | 8 | New node address |
| rx_valid | input | 1 | One-cycle strobe marking a received word |
| rx_data | input | 8 | Received byte |
| rx_ninth | input | 1 | Received ninth bit (1 = address character) |
| out_valid | output | 1 | Forwarded data strobe |
| out_data | output | 8 | Forwarded byte |
| out_ninth | output | 1 | Ninth bit of the forwarded word |
| addr_hit | output | 1 | One-cycle strobe on a matching address character |
| irq | output | 1 | Sticky address-character interrupt |
| addressed | output | 1 | Node is currently selected |

## Verification
The directed part walks one session from start to finish:
- data sent before any address, to show dropping;
- a matching address, then data, to show forwarding;
- a foreign address, then data, to show that the session ends.

It also covers the corner cases:
- a repeated match, showing that the strobe fires again;
- set and clear of the interrupt in the same cycle;
- an address write in the same cycle as an address character, showing that the old address is still used;
- transparent mode with an address character.

The random part mixes data and address characters. Address bytes are biased towards the current node address, so match and mismatch both occur often. The enable, the mask and the clear are toggled throughout. Comparing every cycle with a bench model separates the following mistakes: forwarding in the wrong state, losing the session on data, treating a mismatch as a match, and letting clear win over set.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS   = 2'd0,
        ST_HUNT     = 2'd1,
        ST_SELECTED = 2'd2
    } sess_state_t;

endpackage

// File: rtl/mdrop_addr_reg.sv
module mdrop_addr_reg #(
    parameter int              DATA_W     = 8,
    parameter logic [DATA_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] addr_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= RESET_ADDR;
        end else if (wr_en) begin
            addr_q <= wr_data;
        end
    end

endmodule

// File: rtl/mdrop_irq_latch.sv
module mdrop_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    // set has priority so an event arriving with the acknowledge is kept
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else if (set_i) begin
            irq_o <= 1'b1;
        end else if (clr_i) begin
            irq_o <= 1'b0;
        end
    end

endmodule

// File: rtl/mdrop_session_fsm.sv
module mdrop_session_fsm
    import mdrop_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filt_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_ninth,
    input  logic [DATA_W-1:0] node_addr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ninth,
    output logic              addr_hit,
    output logic              addressed
);

    sess_state_t state_q, state_d;

    logic is_addr_word;
    logic is_data_word;
    logic byte_match;
    logic fwd_d;
    logic hit_d;

    assign is_addr_word = rx_valid &&  rx_ninth;
    assign is_data_word = rx_valid && !rx_ninth;
    assign byte_match   = (rx_data == node_addr);

    // next state and decisions
    always_comb begin
        state_d = state_q;
        fwd_d   = 1'b0;
        hit_d   = 1'b0;
        if (!filt_en) begin
            state_d = ST_BYPASS;
            fwd_d   = rx_valid;
        end else begin
            unique case (state_q)
                ST_BYPASS: begin
                    if (is_addr_word && byte_match) begin
                        state_d = ST_SELECTED;
                        hit_d   = 1'b1;
                    end else begin
                        state_d = ST_HUNT;
                    end
                end
                ST_HUNT: begin
                    if (is_addr_word && byte_match) begin
                        state_d = ST_SELECTED;
                        hit_d   = 1'b1;
                    end
                end
                ST_SELECTED: begin
                    if (is_addr_word) begin
                        if (byte_match) begin
                            hit_d = 1'b1;
                        end else begin
                            state_d = ST_HUNT;
                        end
                    end else if (is_data_word) begin
                        fwd_d = 1'b1;
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BYPASS;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_ninth <= 1'b0;
            addr_hit  <= 1'b0;
        end else begin
            out_valid <= fwd_d;
            addr_hit  <= hit_d;
            if (fwd_d) begin
                out_data  <= rx_data;
                out_ninth <= rx_ninth;
            end
        end
    end

    assign addressed = (state_q == ST_SELECTED);

endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
    import mdrop_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [DATA_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              filt_en,
    input  logic              irq_en,
    input  logic              irq_clear,
    input  logic              addr_wr,
    input  logic [DATA_W-1:0] addr_wdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_ninth,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ninth,
    output logic              addr_hit,
    output logic              irq,
    output logic              addressed
);

    logic [DATA_W-1:0] node_addr_q;
    logic              irq_set;

    mdrop_addr_reg #(
        .DATA_W     (DATA_W),
        .RESET_ADDR (RESET_ADDR)
    ) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (addr_wr),
        .wr_data (addr_wdata),
        .addr_q  (node_addr_q)
    );

    mdrop_session_fsm #(
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .filt_en   (filt_en),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_ninth  (rx_ninth),
        .node_addr (node_addr_q),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ninth (out_ninth),
        .addr_hit  (addr_hit),
        .addressed (addressed)
    );

    // every node flags every address character, independent of match
    assign irq_set = rx_valid && rx_ninth && irq_en;

    mdrop_irq_latch u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (irq_set),
        .clr_i (irq_clear),
        .irq_o (irq)
    );

endmodule

// File: rtl/mdrop_checker.sv
module mdrop_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              filt_en,
    input logic              irq_en,
    input logic              irq_clear,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_ninth,
    input logic [DATA_W-1:0] node_addr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              addr_hit,
    input logic              irq,
    input logic              addressed
);

    p_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        filt_en && rx_valid && rx_ninth && (rx_data == node_addr)
        |=> addressed && addr_hit && !out_valid);

    p_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        filt_en && rx_valid && rx_ninth && (rx_data != node_addr)
        |=> !addressed && !addr_hit && !out_valid);

    p_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
        filt_en && addressed && rx_valid && !rx_ninth
        |=> out_valid && (out_data == $past(rx_data)));

    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        filt_en && !addressed && rx_valid && !rx_ninth
        |=> !out_valid && !addressed);

    p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_ninth && irq_en |=> irq);

    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clear |=> irq);

    p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear && !(rx_valid && rx_ninth && irq_en) |=> !irq);

    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en && rx_valid |=> out_valid && !addr_hit && !addressed);

    p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !out_valid && !addr_hit);

endmodule

bind mdrop_addr_filter mdrop_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .filt_en   (filt_en),
    .irq_en    (irq_en),
    .irq_clear (irq_clear),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ninth  (rx_ninth),
    .node_addr (node_addr_q),
    .out_valid (out_valid),
    .out_data  (out_data),
    .addr_hit  (addr_hit),
    .irq       (irq),
    .addressed (addressed)
);

// File: tb/tb_mdrop_addr_filter.sv
module tb_mdrop_addr_filter;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         filt_en = 1'b0, irq_en = 1'b0, irq_clear = 1'b0, addr_wr = 1'b0;
    logic [W-1:0] addr_wdata = '0;
    logic         rx_valid = 1'b0, rx_ninth = 1'b0;
    logic [W-1:0] rx_data = '0;
    logic         out_valid, out_ninth, addr_hit, irq, addressed;
    logic [W-1:0] out_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // bench model
    logic         m_sel = 1'b0;
    logic         m_irq = 1'b0;
    logic [W-1:0] m_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdrop_addr_filter #(.DATA_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .irq_en(irq_en),
        .irq_clear(irq_clear), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ninth(rx_ninth),
        .out_valid(out_valid), .out_data(out_data), .out_ninth(out_ninth),
        .addr_hit(addr_hit), .irq(irq), .addressed(addressed)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit f_fwd(bit en, bit sel, bit v, bit n);
        return v && (!en || (sel && !n));
    endfunction

    function automatic bit f_hit(bit en, bit v, bit n, logic [W-1:0] d, logic [W-1:0] a);
        return v && en && n && (d == a);
    endfunction

    function automatic bit f_sel(bit en, bit sel, bit v, bit n, logic [W-1:0] d, logic [W-1:0] a);
        if (!en) return 1'b0;
        if (v && n) return (d == a);
        return sel;
    endfunction

    function automatic bit f_irq(bit cur, bit v, bit n, bit ie, bit clr);
        if (v && n && ie) return 1'b1;
        if (clr) return 1'b0;
        return cur;
    endfunction

    // drive one cycle at the negative edge, compare after the next one
    task automatic step(input bit en, input bit ie, input bit clr,
                        input bit wr, input logic [W-1:0] wd,
                        input bit v, input bit n, input logic [W-1:0] d);
        bit e_fwd, e_hit, e_sel, e_irq;
        string tag, itag;
        filt_en = en; irq_en = ie; irq_clear = clr; addr_wr = wr;
        addr_wdata = wd; rx_valid = v; rx_ninth = n; rx_data = d;
        e_fwd = f_fwd(en, m_sel, v, n);
        e_hit = f_hit(en, v, n, d, m_addr);
        e_sel = f_sel(en, m_sel, v, n, d, m_addr);
        e_irq = f_irq(m_irq, v, n, ie, clr);
        if (!v)          tag = "R10";
        else if (!en)    tag = "R8";
        else if (n)      tag = (d == m_addr) ? "R2" : "R3";
        else             tag = m_sel ? "R4" : "R5";
        itag = (v && n) ? "R6" : "R7";
        @(posedge clk);
        @(negedge clk);
        m_sel = e_sel; m_irq = e_irq;
        if (wr) m_addr = wd;
        check(out_valid == e_fwd, tag, "out_valid", int'(out_valid), int'(e_fwd));
        check(addr_hit == e_hit, tag, "addr_hit", int'(addr_hit), int'(e_hit));
        check(addressed == e_sel, tag, "addressed", int'(addressed), int'(e_sel));
        check(irq == e_irq, itag, "irq", int'(irq), int'(e_irq));
        if (e_fwd) begin
            check(out_data == d, tag, "out_data", int'(out_data), int'(d));
            check(out_ninth == (n && !en), tag, "out_ninth", int'(out_ninth), int'(n && !en));
        end
        rx_valid = 1'b0; irq_clear = 1'b0; addr_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [W-1:0] d;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(addressed == 1'b0, "R1", "addressed", int'(addressed), 0);
        check(irq == 1'b0, "R1", "irq", int'(irq), 0);
        check(out_valid == 1'b0, "R1", "out_valid", int'(out_valid), 0);
        check(addr_hit == 1'b0, "R1", "addr_hit", int'(addr_hit), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: default node address 00 matches an address character 00
        step(1, 0, 0, 0, 8'h00, 1, 1, 8'h00);
        step(1, 0, 0, 0, 8'h00, 1, 1, 8'h77);
        // R9: load 5A
        step(1, 0, 0, 1, 8'h5A, 0, 0, 8'h00);
        // R5: data while hunting is dropped
        step(1, 0, 0, 0, 8'h00, 1, 0, 8'h42);
        // R2 + R6: matching address with interrupt unmasked
        step(1, 1, 0, 0, 8'h00, 1, 1, 8'h5A);
        // R4: data while selected is forwarded
        step(1, 1, 0, 0, 8'h00, 1, 0, 8'h11);
        step(1, 1, 0, 0, 8'h00, 1, 0, 8'hEE);
        // R10: idle cycle, no strobes; R7: irq held
        step(1, 1, 0, 0, 8'h00, 0, 0, 8'h99);
        // R2: repeated match fires the strobe again
        step(1, 1, 0, 0, 8'h00, 1, 1, 8'h5A);
        // R7: clear
        step(1, 1, 1, 0, 8'h00, 0, 0, 8'h00);
        // R3: foreign address ends the session
        step(1, 0, 0, 0, 8'h00, 1, 1, 8'h33);
        step(1, 0, 0, 0, 8'h00, 1, 0, 8'h21);
        // R7: set and clear together -> set wins
        step(1, 1, 1, 0, 8'h00, 1, 1, 8'h34);
        // R6: masked address character leaves irq alone after clear
        step(1, 0, 1, 0, 8'h00, 0, 0, 8'h00);
        step(1, 0, 0, 0, 8'h00, 1, 1, 8'h5A);
        // R9: same-cycle write still compares the old address (5A)
        step(1, 0, 0, 1, 8'hC3, 1, 1, 8'hC3);
        step(1, 0, 0, 0, 8'h00, 1, 1, 8'hC3);
        // R8: transparent mode forwards both kinds
        step(0, 1, 0, 0, 8'h00, 1, 1, 8'hC3);
        step(0, 1, 1, 0, 8'h00, 1, 0, 8'h3C);
        step(1, 0, 0, 0, 8'h00, 1, 0, 8'h3C);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit en, ie, clr, wr, v, n;
            logic [W-1:0] wd;
            en  = ($urandom_range(0, 9) != 0);
            ie  = ($urandom_range(0, 3) != 0);
            clr = ($urandom_range(0, 5) == 0);
            wr  = ($urandom_range(0, 60) == 0);
            wd  = 8'($urandom_range(0, 3));
            v   = ($urandom_range(0, 4) != 0);
            n   = ($urandom_range(0, 3) == 0);
            d   = ($urandom_range(0, 1) == 0) ? m_addr : 8'($urandom_range(0, 255));
            step(en, ie, clr, wr, wd, v, n, d);
        end
        finish_run();
    end

endmodule